// File: doc/BRIEF.md
# ADC Sample Window Limit Monitor

This block watches the stream of 10-bit conversion results coming out of an analog-to-digital converter and flags samples that leave a programmed window. Each result arrives with a one-cycle valid strobe and a channel tag naming its source. The tag can name one of ten sources: codes 0 to 3 are the external inputs and codes 4 to 9 are the internal channels.

Four independent limit pairs can each be bound to one channel. A pair holds a low bound, a high bound, an enable and an interrupt enable. When an enabled pair sees a sample from its channel that falls below its low bound, it sets a sticky low flag. A sample above its high bound sets a sticky high flag. The flags stay set until software writes ones to the matching clear inputs.

Each pair drives its own interrupt line. A single wake output merges all flags whose interrupt enable is set. No processor action is needed, so the wake output can pull a sleeping processor out of a low-power state.

Top module: `adc_window_monitor`

## Requirements
- R1: Samples and limits are unsigned 10-bit codes (0x000 to 0x3FF, full scale 0x3FF), and every comparison is unsigned over all 10 bits.
- R2: While `rst` is high, and on the first clock edge after it, all low flags, high flags, per-pair interrupts and `wake` are 0.
- R3: A valid sample that reaches a pair and is strictly below that pair's low limit sets the pair's low flag at the next rising clock edge. A sample equal to the low limit leaves the flag unchanged.
- R4: A valid sample that reaches a pair and is strictly above that pair's high limit sets the pair's high flag at the next rising clock edge. A sample equal to the high limit leaves the flag unchanged.
- R5: A sample reaches pair i only when `pair_en[i]` is 1 and the 4-bit field `pair_chan[4*i+3:4*i]` equals the sample's channel tag. Disabled or non-matching pairs never change their flags.
- R6: Samples whose channel tag is 10 to 15 are discarded. This holds even if a pair's channel field is set to that code.
- R7: Flags are sticky: later in-range samples, disabling the pair and changing its limits do not clear them.
- R8: A 1 on `clr_low[i]` or `clr_high[i]` clears only that flag at the next edge. When a violation that sets the same flag arrives in the same cycle as its clear, the flag ends up set.
- R9: `irq[i]` is `(flag_low[i] | flag_high[i]) & pair_irq_en[i]`, and `wake` is the OR of all `irq` bits. Both are registered and change on the same edge as the flags they follow.
- R10: `wake` stays high until every flag of an interrupt-enabled pair has been cleared or its interrupt enable has been dropped. A flag on a pair whose interrupt enable is 0 never raises `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 10 | Conversion result |
| smp_chan | input | 4 | Channel tag of the sample |
| pair_en | input | 4 | Per-pair enable |
| pair_chan | input | 16 | Per-pair channel select, 4 bits per pair |
| pair_lo | input | 40 | Per-pair low limit, 10 bits per pair |
| pair_hi | input | 40 | Per-pair high limit, 10 bits per pair |
| pair_irq_en | input | 4 | Per-pair interrupt enable |
| clr_low | input | 4 | Write-one-to-clear strobes for low flags |
| clr_high | input | 4 | Write-one-to-clear strobes for high flags |
| flag_low | output | 4 | Sticky below-window flags |
| flag_high | output | 4 | Sticky above-window flags |
| irq | output | 4 | Per-pair interrupt |
| wake | output | 1 | Wake request, OR of enabled interrupts |

## Verification
A table walks samples one below, exactly at and one above each bound. The samples are sent on bound channels, on an unbound channel and on a channel shared by an enabled pair and a disabled pair. This separates strict from inclusive comparison and checks that channel matching and enable gating work. Directed sequences then cover three things. The first is a clear arriving together with a fresh violation, which shows whether set or clear has priority. The second is clearing one flag kind while the other stays set. The third is interrupt enables switched around standing flags, which shows that `wake` follows only enabled pairs. A pair bound to the out-of-range tag 10 shows that invalid tags are dropped.

// File: rtl/adc_wm_pkg.sv
package adc_wm_pkg;
  localparam int DATA_W   = 10;
  localparam int CHAN_W   = 4;
  localparam int NUM_CHAN = 10;
  localparam int NUM_PAIR = 4;

  typedef struct packed {
    logic below;
    logic above;
  } win_hit_t;
endpackage

// File: rtl/awm_window_cmp.sv
module awm_window_cmp
  import adc_wm_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int CW    = CHAN_W,
  parameter int NCHAN = NUM_CHAN
) (
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [CW-1:0] smp_chan,
  input  logic          en,
  input  logic [CW-1:0] sel_chan,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  output win_hit_t      hit
);
  localparam logic [CW-1:0] CHAN_END = CW'(NCHAN);

  logic reach;

  always_comb begin
    reach     = smp_valid && en && (smp_chan == sel_chan) && (smp_chan < CHAN_END);
    hit.below = reach && (smp_data < lim_lo);
    hit.above = reach && (smp_data > lim_hi);
  end
endmodule

// File: rtl/awm_flag_cell.sv
module awm_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  always_comb nxt_o = (q_o && !clr_i) || set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/awm_irq_merge.sv
module awm_irq_merge #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] nxt_low,
  input  logic [NP-1:0] nxt_high,
  input  logic [NP-1:0] irq_en,
  output logic [NP-1:0] irq_q,
  output logic          wake_q
);
  logic [NP-1:0] irq_d;

  always_comb irq_d = (nxt_low | nxt_high) & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= |irq_d;
    end
  end
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adc_wm_pkg::*;
#(
  parameter int NP    = NUM_PAIR,
  parameter int DW    = DATA_W,
  parameter int CW    = CHAN_W,
  parameter int NCHAN = NUM_CHAN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_data,
  input  logic [CW-1:0]    smp_chan,
  input  logic [NP-1:0]    pair_en,
  input  logic [NP*CW-1:0] pair_chan,
  input  logic [NP*DW-1:0] pair_lo,
  input  logic [NP*DW-1:0] pair_hi,
  input  logic [NP-1:0]    pair_irq_en,
  input  logic [NP-1:0]    clr_low,
  input  logic [NP-1:0]    clr_high,
  output logic [NP-1:0]    flag_low,
  output logic [NP-1:0]    flag_high,
  output logic [NP-1:0]    irq,
  output logic             wake
);
  logic [NP-1:0] nxt_low;
  logic [NP-1:0] nxt_high;

  for (genvar g = 0; g < NP; g++) begin : g_pair
    win_hit_t hit;

    awm_window_cmp #(.DW(DW), .CW(CW), .NCHAN(NCHAN)) u_cmp (
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .smp_chan  (smp_chan),
      .en        (pair_en[g]),
      .sel_chan  (pair_chan[g*CW +: CW]),
      .lim_lo    (pair_lo[g*DW +: DW]),
      .lim_hi    (pair_hi[g*DW +: DW]),
      .hit       (hit)
    );

    awm_flag_cell u_low (
      .clk   (clk),
      .rst   (rst),
      .set_i (hit.below),
      .clr_i (clr_low[g]),
      .nxt_o (nxt_low[g]),
      .q_o   (flag_low[g])
    );

    awm_flag_cell u_high (
      .clk   (clk),
      .rst   (rst),
      .set_i (hit.above),
      .clr_i (clr_high[g]),
      .nxt_o (nxt_high[g]),
      .q_o   (flag_high[g])
    );
  end

  awm_irq_merge #(.NP(NP)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .nxt_low  (nxt_low),
    .nxt_high (nxt_high),
    .irq_en   (pair_irq_en),
    .irq_q    (irq),
    .wake_q   (wake)
  );
endmodule

// File: rtl/adc_window_monitor_chk.sv
module adc_window_monitor_chk #(
  parameter int NP    = 4,
  parameter int DW    = 10,
  parameter int CW    = 4,
  parameter int NCHAN = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic [DW-1:0]    smp_data,
  input logic [CW-1:0]    smp_chan,
  input logic [NP-1:0]    pair_en,
  input logic [NP*CW-1:0] pair_chan,
  input logic [NP*DW-1:0] pair_lo,
  input logic [NP*DW-1:0] pair_hi,
  input logic [NP-1:0]    pair_irq_en,
  input logic [NP-1:0]    clr_low,
  input logic [NP-1:0]    clr_high,
  input logic [NP-1:0]    flag_low,
  input logic [NP-1:0]    flag_high,
  input logic [NP-1:0]    irq,
  input logic             wake
);
  localparam logic [CW-1:0] CHAN_END = CW'(NCHAN);

  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (flag_low == '0 && flag_high == '0 && irq == '0 && !wake));

  for (genvar i = 0; i < NP; i++) begin : g_chk
    a_r3_low_sets: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && pair_en[i] && smp_chan == pair_chan[i*CW +: CW] && smp_chan < CHAN_END
       && smp_data < pair_lo[i*DW +: DW]) |=> flag_low[i]);

    a_r4_high_sets: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && pair_en[i] && smp_chan == pair_chan[i*CW +: CW] && smp_chan < CHAN_END
       && smp_data > pair_hi[i*DW +: DW]) |=> flag_high[i]);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      (!pair_en[i] && !flag_low[i] && !flag_high[i]) |=> (!flag_low[i] && !flag_high[i]));

    a_r6_bad_tag_quiet: assert property (@(posedge clk) disable iff (rst)
      (smp_chan >= CHAN_END && !flag_low[i] && !flag_high[i]) |=> (!flag_low[i] && !flag_high[i]));

    a_r7_low_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_low[i] && !clr_low[i]) |=> flag_low[i]);

    a_r7_high_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_high[i] && !clr_high[i]) |=> flag_high[i]);

    a_r8_low_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_low[i] && !smp_valid) |=> !flag_low[i]);

    a_r8_high_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_high[i] && !smp_valid) |=> !flag_high[i]);

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
      ((flag_low[i] || flag_high[i]) && $past(pair_irq_en[i])) |-> (irq[i] && wake));
  end

  a_r10_wake_needs_irq: assert property (@(posedge clk) disable iff (rst)
    wake |-> (irq != '0));
endmodule

bind adc_window_monitor adc_window_monitor_chk #(
  .NP(NP), .DW(DW), .CW(CW), .NCHAN(NCHAN)
) u_chk (.*);

// File: tb/adc_window_monitor_test.sv
module adc_window_monitor_test;
  localparam int NP = 4;
  localparam int DW = 10;
  localparam int CW = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             smp_valid;
  logic [DW-1:0]    smp_data;
  logic [CW-1:0]    smp_chan;
  logic [NP-1:0]    pair_en;
  logic [NP*CW-1:0] pair_chan;
  logic [NP*DW-1:0] pair_lo;
  logic [NP*DW-1:0] pair_hi;
  logic [NP-1:0]    pair_irq_en;
  logic [NP-1:0]    clr_low;
  logic [NP-1:0]    clr_high;
  logic [NP-1:0]    flag_low;
  logic [NP-1:0]    flag_high;
  logic [NP-1:0]    irq;
  logic             wake;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  adc_window_monitor uut (.*);

  // vector: chan[21:18] data[17:8] expected low flags[7:4] expected high flags[3:0]
  localparam int NVEC = 11;
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd0, 10'd99,   4'b0001, 4'b0000},  // R3 one below low
    {4'd0, 10'd100,  4'b0000, 4'b0000},  // R3 equal to low
    {4'd0, 10'd900,  4'b0000, 4'b0000},  // R4 equal to high
    {4'd0, 10'd901,  4'b0000, 4'b0001},  // R4 one above high
    {4'd3, 10'd5,    4'b0010, 4'b0000},  // R5 pair1 hits, disabled pair3 not
    {4'd3, 10'd700,  4'b0000, 4'b0010},  // R5 shared channel
    {4'd9, 10'h3FF,  4'b0000, 4'b0100},  // R1 full scale above pair2
    {4'd9, 10'd250,  4'b0000, 4'b0000},  // R1 inside window
    {4'd5, 10'd0,    4'b0000, 4'b0000},  // R5 unbound channel
    {4'd1, 10'h3FF,  4'b0000, 4'b0000},  // R5 unbound channel
    {4'd9, 10'd199,  4'b0100, 4'b0000}   // R3 pair2 below
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [CW-1:0] ch, input logic [DW-1:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_low = '1; clr_high = '1;
    @(negedge clk);
    clr_low = '0; clr_high = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; smp_valid = 1'b0; smp_data = '0; smp_chan = '0;
    pair_en = 4'b0111;
    pair_chan = {4'd3, 4'd9, 4'd3, 4'd0};
    pair_lo   = {10'd500, 10'd200, 10'd10, 10'd100};
    pair_hi   = {10'd600, 10'd300, 10'd20, 10'd900};
    pair_irq_en = '0; clr_low = '0; clr_high = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset flags", {flag_low, flag_high}, 32'h0);
    chk("R2 reset irq/wake", {irq, wake}, 32'h0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][21:18], VEC[v][17:8]);
      chk($sformatf("R3/R4/R5 vector %0d low", v), flag_low, VEC[v][7:4]);
      chk($sformatf("R3/R4/R5 vector %0d high", v), flag_high, VEC[v][3:0]);
      clear_all();
    end

    // R7: sticky through in-range sample, disable and limit change
    send(4'd0, 10'd50);
    send(4'd0, 10'd500);
    @(negedge clk); pair_en[0] = 1'b0; pair_lo[9:0] = 10'd0;
    @(negedge clk);
    chk("R7 sticky low", flag_low, 4'b0001);
    pair_en[0] = 1'b1; pair_lo[9:0] = 10'd100;

    // R8: clearing high leaves low set
    send(4'd0, 10'd950);
    @(negedge clk); clr_high = 4'b0001;
    @(negedge clk); clr_high = '0;
    chk("R8 high cleared", flag_high, 4'b0000);
    chk("R8 low kept", flag_low, 4'b0001);

    // R8: clear together with new violation -> set wins
    @(negedge clk);
    clr_low = 4'b0001; smp_valid = 1'b1; smp_chan = 4'd0; smp_data = 10'd3;
    @(negedge clk);
    clr_low = '0; smp_valid = 1'b0;
    chk("R8 set wins", flag_low, 4'b0001);
    @(negedge clk); clr_low = 4'b0001;
    @(negedge clk); clr_low = '0;
    chk("R8 clear alone", flag_low, 4'b0000);

    // R6: invalid tag ignored even when pair bound to it
    @(negedge clk); pair_chan[15:12] = 4'd10; pair_en[3] = 1'b1;
    send(4'd10, 10'd0);
    chk("R6 bad tag low", flag_low, 4'b0000);
    send(4'd10, 10'h3FF);
    chk("R6 bad tag high", flag_high, 4'b0000);
    pair_en[3] = 1'b0;

    // R9/R10: interrupts and wake
    @(negedge clk); pair_irq_en = 4'b0001;
    send(4'd0, 10'd10);
    chk("R9 irq same edge", irq, 4'b0001);
    chk("R9 wake same edge", {31'd0, wake}, 32'd1);
    send(4'd9, 10'd400);
    chk("R10 disabled pair irq", irq, 4'b0001);
    clear_all();
    send(4'd9, 10'd400);
    chk("R10 wake off without enable", {31'd0, wake}, 32'd0);
    @(negedge clk); pair_irq_en = 4'b0100;
    @(negedge clk);
    chk("R9 enable raises wake", {irq, wake}, {27'd0, 4'b0100, 1'b1});
    @(negedge clk); clr_high = 4'b0100;
    @(negedge clk); clr_high = '0;
    chk("R10 wake drops after clear", {irq, wake}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule